// File: doc/BRIEF.md
# Upper-Immediate Pair Fuser and Conversion Splitter

This block is the first of two decode stages in a four-wide RISC-V front end. Each cycle it takes a group of up to four 32-bit instructions, one valid bit per lane, and emits one registered micro-op record per lane. When an upper-immediate instruction (`lui` or `auipc`) is followed in the next lane by an `addi`, a load or a `jalr` that reads and writes the same register, the two are merged into one macro-op. That macro-op carries the full 32-bit offset, and the lane that held the second instruction is marked empty. A merged `auipc` + load is then a single PC-relative load, and a merged `auipc` + `jalr` is a single PC-relative jump.

In the same stage, float/integer conversions are tagged for splitting. The conversion itself runs on the floating-point unit, and a companion micro-op moves the integer operand through the memory unit. The companion reads the integer register before the conversion (integer to float) or writes it after the conversion (float to integer). All other instructions pass through with their raw encoding for the second decode stage.

Top module: `fuse_pre_decode`

## Requirements
- R1: While reset is asserted, and in the cycle after a clock edge taken in reset, every `out_vld` bit is 0.
- R2: Outputs are registered with one cycle of latency. A valid lane that neither fuses nor converts yields `out_vld`=1 with kind 0 (plain), `out_insn` equal to the input word, and `out_rd` equal to bits 11:7. An invalid input lane yields `out_vld`=0.
- R3: Six pairs fuse: lui or auipc (opcode 0110111 or 0010111) in lane i, followed in lane i+1 by addi (opcode 0010011, funct3 000), a load (opcode 0000011) or jalr (opcode 1100111, funct3 000). The result is placed in lane i with kind 1 for addi, 2 for a load and 3 for jalr. `out_pcrel` is 1 when the head is auipc and 0 when it is lui.
- R4: A fused lane's `out_imm` is (bits 31:12 of the head shifted left by 12) plus the sign-extended bits 31:20 of the tail, modulo 2^32.
- R5: When lanes i and i+1 fuse, `out_vld[i+1]` is 0 and `out_rd[i]` holds the shared destination register.
- R6: No fusion takes place when the tail's rs1 (bits 19:15) or rd differs from the head's rd, or when that register is x0.
- R7: Only lanes in the same group fuse. A head in lane 3 is never merged with the next group, and a head whose next lane is invalid stays unfused.
- R8: For a fused load, `out_ldw` is the tail's funct3 (0 to 6, covering byte, half, word and double, signed and unsigned). A load with funct3 111 does not fuse. `out_ldw` is 0 for every non-load kind.
- R9: A conversion (opcode 1010011, format bits 26:25 of 00 or 01) is given kind 4 and `out_xfer`=1. `out_xdir` is 0 when bits 31:27 are 11010 (integer to float) and 1 when they are 11000 (float to integer). `out_xfer` is 0 on every other kind.
- R10: Pairing is resolved from lane 0 upward. A lane freed by a pair may not start another pair, and a group can hold two fused pairs (lanes 0+1 and 2+3), or a pair at lanes 1+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | LANES | Per-lane instruction valid |
| in_insn | input | 32*LANES | Instruction words, lane i at bits 32i+31:32i |
| out_vld | output | LANES | Per-lane micro-op valid |
| out_kind | output | 3*LANES | Micro-op kind: 0 plain, 1 fused add, 2 fused load, 3 fused jump, 4 conversion |
| out_pcrel | output | LANES | Fused offset is PC-relative |
| out_rd | output | 5*LANES | Destination register |
| out_imm | output | 32*LANES | Combined 32-bit offset of a fused lane, else 0 |
| out_ldw | output | 3*LANES | Load width and signedness of a fused load |
| out_xfer | output | LANES | Conversion needs a companion integer-move micro-op |
| out_xdir | output | LANES | Companion direction: 1 writes the integer register after conversion |
| out_insn | output | 32*LANES | Raw instruction word of the lane (the head for a fused lane) |

## Verification
The directed cases target the places where fusion logic usually breaks. A negative low immediate must borrow from the upper part; a design that concatenates instead of adding gives an offset that is 4096 too high. A head in lane 3 would steal the next group's first instruction if the design looked across the boundary. A mismatched or zero register would give wrong architectural results if it were merged anyway. A funct3 of 111 on a load would be passed off as a real load width. The random groups draw destinations from only four registers, so matching and mismatching pairs, back-to-back pairs and conversions appear in every lane position. This exposes any error in the left-to-right order or in the clearing of the freed lane.

// File: rtl/fuse_pkg.sv
package fuse_pkg;

    localparam int ILEN = 32;
    localparam int RW   = 5;

    localparam logic [6:0] OPC_LUI   = 7'b0110111;
    localparam logic [6:0] OPC_AUIPC = 7'b0010111;
    localparam logic [6:0] OPC_OPIMM = 7'b0010011;
    localparam logic [6:0] OPC_LOAD  = 7'b0000011;
    localparam logic [6:0] OPC_JALR  = 7'b1100111;
    localparam logic [6:0] OPC_OPFP  = 7'b1010011;

    localparam logic [4:0] F5_F2I = 5'b11000;
    localparam logic [4:0] F5_I2F = 5'b11010;

    typedef enum logic [2:0] {
        UK_PLAIN = 3'd0,
        UK_FADD  = 3'd1,
        UK_FLOAD = 3'd2,
        UK_FJUMP = 3'd3,
        UK_CVT   = 3'd4
    } uop_kind_e;

    typedef enum logic [2:0] {
        IC_OTHER, IC_LUI, IC_AUIPC, IC_ADDI, IC_LOAD, IC_JALR, IC_I2F, IC_F2I
    } insn_cls_e;

    typedef struct packed {
        insn_cls_e     cls;
        logic [RW-1:0] rd;
        logic [RW-1:0] rs1;
        logic [2:0]    f3;
        logic [19:0]   hi;
        logic [11:0]   lo;
    } slot_info_t;

    typedef struct packed {
        logic            vld;
        uop_kind_e       kind;
        logic            pcrel;
        logic [RW-1:0]   rd;
        logic [ILEN-1:0] imm;
        logic [2:0]      ldw;
        logic            xfer;
        logic            xdir;
        logic [ILEN-1:0] insn;
    } uop_t;

endpackage

// File: rtl/fuse_slot_dec.sv
module fuse_slot_dec
    import fuse_pkg::*;
(
    input  logic [ILEN-1:0] insn,
    output slot_info_t      info
);

    always_comb begin
        info     = '0;
        info.rd  = insn[11:7];
        info.rs1 = insn[19:15];
        info.f3  = insn[14:12];
        info.hi  = insn[31:12];
        info.lo  = insn[31:20];
        info.cls = IC_OTHER;
        case (insn[6:0])
            OPC_LUI:   info.cls = IC_LUI;
            OPC_AUIPC: info.cls = IC_AUIPC;
            OPC_OPIMM: if (insn[14:12] == 3'b000) info.cls = IC_ADDI;
            OPC_LOAD:  if (insn[14:12] != 3'b111) info.cls = IC_LOAD;
            OPC_JALR:  if (insn[14:12] == 3'b000) info.cls = IC_JALR;
            OPC_OPFP: begin
                if (insn[26] == 1'b0) begin
                    if (insn[31:27] == F5_F2I)      info.cls = IC_F2I;
                    else if (insn[31:27] == F5_I2F) info.cls = IC_I2F;
                end
            end
            default:   info.cls = IC_OTHER;
        endcase
    end

endmodule

// File: rtl/fuse_pair_chk.sv
module fuse_pair_chk
    import fuse_pkg::*;
(
    input  logic            head_vld,
    input  logic            tail_vld,
    input  slot_info_t      head,
    input  slot_info_t      tail,
    output logic            hit,
    output uop_kind_e       kind,
    output logic [ILEN-1:0] imm,
    output logic [2:0]      ldw
);

    logic head_up;
    logic regs_ok;
    logic [ILEN-1:0] upper;
    logic [ILEN-1:0] lower;

    always_comb begin
        head_up = (head.cls == IC_LUI) || (head.cls == IC_AUIPC);
        regs_ok = (head.rd != '0) && (tail.rs1 == head.rd) && (tail.rd == head.rd);
        upper   = {head.hi, 12'b0};
        lower   = {{(ILEN-12){tail.lo[11]}}, tail.lo};
        kind    = UK_PLAIN;
        ldw     = 3'b000;
        case (tail.cls)
            IC_ADDI: kind = UK_FADD;
            IC_LOAD: begin
                kind = UK_FLOAD;
                ldw  = tail.f3;
            end
            IC_JALR: kind = UK_FJUMP;
            default: kind = UK_PLAIN;
        endcase
        hit = head_vld && tail_vld && head_up && regs_ok && (kind != UK_PLAIN);
        imm = upper + lower;
    end

endmodule

// File: rtl/fuse_pre_decode.sv
module fuse_pre_decode
    import fuse_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [LANES-1:0]     in_vld,
    input  logic [LANES*32-1:0]  in_insn,
    output logic [LANES-1:0]     out_vld,
    output logic [LANES*3-1:0]   out_kind,
    output logic [LANES-1:0]     out_pcrel,
    output logic [LANES*5-1:0]   out_rd,
    output logic [LANES*32-1:0]  out_imm,
    output logic [LANES*3-1:0]   out_ldw,
    output logic [LANES-1:0]     out_xfer,
    output logic [LANES-1:0]     out_xdir,
    output logic [LANES*32-1:0]  out_insn
);

    localparam int PAIRS = LANES - 1;

    logic [ILEN-1:0] lane_insn [LANES];
    slot_info_t      info      [LANES];
    logic [LANES-1:0] pair_hit;
    uop_kind_e       pair_kind [LANES];
    logic [ILEN-1:0] pair_imm  [LANES];
    logic [2:0]      pair_ldw  [LANES];

    uop_t [LANES-1:0] st_d;
    uop_t [LANES-1:0] st_q;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_insn[g] = in_insn[g*ILEN +: ILEN];

        fuse_slot_dec u_dec (
            .insn (lane_insn[g]),
            .info (info[g])
        );

        if (g < PAIRS) begin : g_pair
            fuse_pair_chk u_pair (
                .head_vld (in_vld[g]),
                .tail_vld (in_vld[g+1]),
                .head     (info[g]),
                .tail     (info[g+1]),
                .hit      (pair_hit[g]),
                .kind     (pair_kind[g]),
                .imm      (pair_imm[g]),
                .ldw      (pair_ldw[g])
            );
        end else begin : g_edge
            assign pair_hit[g]  = 1'b0;
            assign pair_kind[g] = UK_PLAIN;
            assign pair_imm[g]  = '0;
            assign pair_ldw[g]  = 3'b000;
        end

        assign out_vld[g]             = st_q[g].vld;
        assign out_kind[g*3 +: 3]     = st_q[g].kind;
        assign out_pcrel[g]           = st_q[g].pcrel;
        assign out_rd[g*RW +: RW]     = st_q[g].rd;
        assign out_imm[g*ILEN +: ILEN] = st_q[g].imm;
        assign out_ldw[g*3 +: 3]      = st_q[g].ldw;
        assign out_xfer[g]            = st_q[g].xfer;
        assign out_xdir[g]            = st_q[g].xdir;
        assign out_insn[g*ILEN +: ILEN] = st_q[g].insn;
    end

    always_comb begin
        logic consumed;
        st_d     = '0;
        consumed = 1'b0;
        for (int i = 0; i < LANES; i++) begin
            if (consumed) begin
                consumed = 1'b0;
            end else if (in_vld[i]) begin
                st_d[i].vld  = 1'b1;
                st_d[i].insn = lane_insn[i];
                st_d[i].rd   = info[i].rd;
                st_d[i].kind = UK_PLAIN;
                if (pair_hit[i]) begin
                    st_d[i].kind  = pair_kind[i];
                    st_d[i].pcrel = (info[i].cls == IC_AUIPC);
                    st_d[i].imm   = pair_imm[i];
                    st_d[i].ldw   = pair_ldw[i];
                    consumed      = 1'b1;
                end else if (info[i].cls == IC_I2F || info[i].cls == IC_F2I) begin
                    st_d[i].kind = UK_CVT;
                    st_d[i].xfer = 1'b1;
                    st_d[i].xdir = (info[i].cls == IC_F2I);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/fuse_pre_decode_chk.sv
module fuse_pre_decode_chk #(
    parameter int LANES = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic [LANES-1:0]    in_vld,
    input logic [LANES-1:0]    out_vld,
    input logic [LANES*3-1:0]  out_kind,
    input logic [LANES*5-1:0]  out_rd,
    input logic [LANES*3-1:0]  out_ldw,
    input logic [LANES-1:0]    out_xfer
);

    AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> (out_vld == '0)); // R1

    for (genvar i = 0; i < LANES; i++) begin : g_ln
        logic [2:0] k;
        logic       fused;
        assign k     = out_kind[i*3 +: 3];
        assign fused = out_vld[i] && (k == 3'd1 || k == 3'd2 || k == 3'd3);

        AST_FROM_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
            out_vld[i] |-> $past(in_vld[i])); // R2

        AST_FUSED_RD_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
            fused |-> (out_rd[i*5 +: 5] != 5'd0)); // R6

        AST_LDW_LOAD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
            (out_vld[i] && k != 3'd2) |-> (out_ldw[i*3 +: 3] == 3'd0)); // R8

        AST_XFER_CVT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
            (out_vld[i] && out_xfer[i]) |-> (k == 3'd4)); // R9

        if (i < LANES - 1) begin : g_nx
            AST_TAIL_FREED: assert property (@(posedge clk) disable iff (!rst_n)
                fused |-> !out_vld[i+1]); // R5
        end else begin : g_last
            AST_NO_CROSS_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
                !fused); // R7
        end
    end

endmodule

bind fuse_pre_decode fuse_pre_decode_chk #(.LANES(LANES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_vld   (in_vld),
    .out_vld  (out_vld),
    .out_kind (out_kind),
    .out_rd   (out_rd),
    .out_ldw  (out_ldw),
    .out_xfer (out_xfer)
);

// File: tb/sim_fuse_pre_decode.sv
`timescale 1ns/1ps
module sim_fuse_pre_decode;

    localparam int LN = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [LN-1:0]   in_vld = '0;
    logic [LN*32-1:0] in_insn = '0;
    logic [LN-1:0]   out_vld;
    logic [LN*3-1:0] out_kind;
    logic [LN-1:0]   out_pcrel;
    logic [LN*5-1:0] out_rd;
    logic [LN*32-1:0] out_imm;
    logic [LN*3-1:0] out_ldw;
    logic [LN-1:0]   out_xfer;
    logic [LN-1:0]   out_xdir;
    logic [LN*32-1:0] out_insn;

    int n_chk = 0;
    int n_bad = 0;

    logic [31:0] grp [LN];
    logic [LN-1:0] gv;

    logic        e_vld [LN];
    logic [2:0]  e_kind [LN];
    logic        e_pc [LN];
    logic [4:0]  e_rd [LN];
    logic [31:0] e_imm [LN];
    logic [2:0]  e_ldw [LN];
    logic        e_xf [LN];
    logic        e_xd [LN];

    always #2 clk = ~clk;

    fuse_pre_decode #(.LANES(LN)) u0 (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_insn(in_insn),
        .out_vld(out_vld), .out_kind(out_kind), .out_pcrel(out_pcrel),
        .out_rd(out_rd), .out_imm(out_imm), .out_ldw(out_ldw),
        .out_xfer(out_xfer), .out_xdir(out_xdir), .out_insn(out_insn)
    );

    function automatic logic [31:0] i_lui(input logic [4:0] rd, input logic [19:0] u);
        return {u, rd, 7'b0110111};
    endfunction
    function automatic logic [31:0] i_auipc(input logic [4:0] rd, input logic [19:0] u);
        return {u, rd, 7'b0010111};
    endfunction
    function automatic logic [31:0] i_addi(input logic [4:0] rd, input logic [4:0] rs, input logic [11:0] s);
        return {s, rs, 3'b000, rd, 7'b0010011};
    endfunction
    function automatic logic [31:0] i_load(input logic [4:0] rd, input logic [4:0] rs, input logic [2:0] f3, input logic [11:0] s);
        return {s, rs, f3, rd, 7'b0000011};
    endfunction
    function automatic logic [31:0] i_jalr(input logic [4:0] rd, input logic [4:0] rs, input logic [11:0] s);
        return {s, rs, 3'b000, rd, 7'b1100111};
    endfunction
    function automatic logic [31:0] i_cvt(input logic [4:0] f5, input logic fmt, input logic [4:0] rd, input logic [4:0] rs);
        return {f5, 1'b0, fmt, 5'd0, rs, 3'b111, rd, 7'b1010011};
    endfunction
    function automatic logic [31:0] i_add(input logic [4:0] rd, input logic [4:0] rs);
        return {7'd0, 5'd3, rs, 3'b000, rd, 7'b0110011};
    endfunction

    // tail kind for lane j: 0 none, 1 addi, 2 load, 3 jalr
    function automatic int tail_kind(input logic [31:0] w);
        if (w[6:0] == 7'b0010011 && w[14:12] == 3'd0) return 1;
        if (w[6:0] == 7'b0000011 && w[14:12] != 3'd7) return 2;
        if (w[6:0] == 7'b1100111 && w[14:12] == 3'd0) return 3;
        return 0;
    endfunction

    task automatic model();
        bit skip = 0;
        for (int j = 0; j < LN; j++) begin
            e_vld[j] = 0; e_kind[j] = 0; e_pc[j] = 0; e_rd[j] = 0;
            e_imm[j] = 0; e_ldw[j] = 0; e_xf[j] = 0; e_xd[j] = 0;
        end
        for (int j = 0; j < LN; j++) begin
            if (skip) begin
                skip = 0;
            end else if (gv[j]) begin
                logic [31:0] h;
                bit up;
                h = grp[j];
                up = (h[6:0] == 7'b0110111) || (h[6:0] == 7'b0010111);
                e_vld[j] = 1; e_rd[j] = h[11:7];
                if (j + 1 < LN && up && gv[j+1] && h[11:7] != 0 &&
                    grp[j+1][19:15] == h[11:7] && grp[j+1][11:7] == h[11:7] &&
                    tail_kind(grp[j+1]) != 0) begin
                    e_kind[j] = 3'(tail_kind(grp[j+1]));
                    e_pc[j] = (h[6:0] == 7'b0010111);
                    e_imm[j] = {h[31:12], 12'd0} + {{20{grp[j+1][31]}}, grp[j+1][31:20]};
                    e_ldw[j] = (e_kind[j] == 3'd2) ? grp[j+1][14:12] : 3'd0;
                    skip = 1;
                end else if (h[6:0] == 7'b1010011 && h[26] == 1'b0 &&
                             (h[31:27] == 5'b11000 || h[31:27] == 5'b11010)) begin
                    e_kind[j] = 3'd4; e_xf[j] = 1; e_xd[j] = (h[31:27] == 5'b11000);
                end
            end
        end
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive at negedge, registered at posedge, sample at next negedge
    task automatic apply(input string tag);
        for (int j = 0; j < LN; j++) in_insn[j*32 +: 32] = grp[j];
        in_vld = gv;
        model();
        @(negedge clk);
        for (int j = 0; j < LN; j++) begin
            logic [127:0] a, e;
            a = {out_vld[j], out_kind[j*3 +: 3], out_pcrel[j], out_rd[j*5 +: 5],
                 out_imm[j*32 +: 32], out_ldw[j*3 +: 3], out_xfer[j], out_xdir[j],
                 (out_vld[j] ? out_insn[j*32 +: 32] : 32'd0)};
            e = {e_vld[j], e_kind[j], e_pc[j], e_rd[j], e_imm[j], e_ldw[j], e_xf[j], e_xd[j],
                 (e_vld[j] ? grp[j] : 32'd0)};
            n_chk++;
            if (a !== e) begin
                n_bad++;
                $display("FAIL %s lane %0d actual=%h expected=%h", tag, j, a, e);
            end
        end
    endtask

    function automatic logic [31:0] rnd_insn();
        logic [4:0] rd = 5'($urandom % 4);
        logic [4:0] rs = ($urandom % 4 == 0) ? 5'($urandom % 4) : rd;
        case ($urandom % 9)
            0: return i_lui(rd, 20'($urandom));
            1: return i_auipc(rd, 20'($urandom));
            2: return i_addi(rd, rs, 12'($urandom));
            3: return i_load(rd, rs, 3'($urandom), 12'($urandom));
            4: return i_jalr(rd, rs, 12'($urandom));
            5: return i_cvt(5'b11000, 1'($urandom), rd, rs);
            6: return i_cvt(5'b11010, 1'($urandom), rd, rs);
            7: return i_add(rd, rs);
            default: return i_lui(rd, 20'($urandom));
        endcase
    endfunction

    initial begin
        #(200000 * 4);
        n_chk++; n_bad++;
        $display("FAIL watchdog R2 actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int j = 0; j < LN; j++) grp[j] = i_add(5'd1, 5'd1);
        gv = '1;
        in_vld = '1;
        in_insn = {LN{i_add(5'd1, 5'd1)}};
        repeat (3) @(negedge clk);
        chk("R1 reset idle", {28'd0, out_vld}, 32'd0);
        rst_n = 1'b1;

        // R2 plain pass-through and invalid lane
        grp[0] = i_add(5'd4, 5'd2); grp[1] = i_add(5'd5, 5'd2);
        grp[2] = i_add(5'd6, 5'd2); grp[3] = i_add(5'd7, 5'd2); gv = 4'b1011;
        apply("R2 plain");
        chk("R2 invalid lane", {31'd0, out_vld[2]}, 32'd0);
        chk("R2 rd", {27'd0, out_rd[15 +: 5]}, 32'd7);

        // R3 R4 R5 lui+addi, two pairs per group (R10)
        grp[0] = i_lui(5'd5, 20'h12345); grp[1] = i_addi(5'd5, 5'd5, 12'h678);
        grp[2] = i_auipc(5'd6, 20'h00001); grp[3] = i_addi(5'd6, 5'd6, 12'hFFF); gv = '1;
        apply("R10 two pairs");
        chk("R4 imm positive", out_imm[31:0], 32'h12345678);
        chk("R4 imm borrow", out_imm[95:64], 32'h00000FFF);
        chk("R5 tail cleared", {28'd0, out_vld}, 32'b0101);
        chk("R3 pcrel auipc", {31'd0, out_pcrel[2]}, 32'd1);

        // R3 R8 jump and load forms
        grp[0] = i_auipc(5'd1, 20'hFFFFF); grp[1] = i_jalr(5'd1, 5'd1, 12'h010);
        grp[2] = i_lui(5'd7, 20'h80000); grp[3] = i_load(5'd7, 5'd7, 3'd2, 12'h800);
        apply("R3 jump and load");
        chk("R3 jump kind", {29'd0, out_kind[2:0]}, 32'd3);
        chk("R8 load width", {29'd0, out_ldw[8:6]}, 32'd2);
        chk("R4 wrap", out_imm[95:64], 32'h7FFFF800);

        // R6 mismatches and x0
        grp[0] = i_lui(5'd5, 20'h1); grp[1] = i_addi(5'd6, 5'd5, 12'h1);
        grp[2] = i_lui(5'd0, 20'h1); grp[3] = i_addi(5'd0, 5'd0, 12'h1);
        apply("R6 no fuse");
        chk("R6 both valid", {28'd0, out_vld}, 32'hF);

        // R7 boundary and invalid tail
        grp[0] = i_lui(5'd2, 20'h3); grp[1] = i_addi(5'd2, 5'd2, 12'h4);
        grp[2] = i_add(5'd9, 5'd9); grp[3] = i_lui(5'd8, 20'h3); gv = 4'b1101;
        apply("R7 invalid tail");
        chk("R7 head unfused", {29'd0, out_kind[2:0]}, 32'd0);
        grp[0] = i_addi(5'd8, 5'd8, 12'h4); grp[1] = i_add(5'd9, 5'd9);
        grp[2] = i_add(5'd9, 5'd9); grp[3] = i_add(5'd9, 5'd9); gv = '1;
        apply("R7 next group");
        chk("R7 lane0 plain", {28'd0, out_vld}, 32'hF);

        // R8 funct3 111 and lbu; R9 conversions; R10 pair at lanes 1+2
        grp[0] = i_lui(5'd3, 20'h5); grp[1] = i_load(5'd3, 5'd3, 3'd7, 12'h0);
        grp[2] = i_lui(5'd3, 20'h5); grp[3] = i_load(5'd3, 5'd3, 3'd4, 12'h0);
        apply("R8 load funct3");
        chk("R8 lbu width", {29'd0, out_ldw[8:6]}, 32'd4);
        grp[0] = i_cvt(5'b11010, 1'b1, 5'd2, 5'd3); grp[1] = i_lui(5'd4, 20'h9);
        grp[2] = i_addi(5'd4, 5'd4, 12'h9); grp[3] = i_cvt(5'b11000, 1'b0, 5'd2, 5'd3);
        apply("R9 R10 conversions and middle pair");
        chk("R9 i2f dir", {30'd0, out_xfer[0], out_xdir[0]}, 32'b10);
        chk("R9 f2i dir", {30'd0, out_xfer[3], out_xdir[3]}, 32'b11);
        chk("R10 middle pair", {28'd0, out_vld}, 32'b1011);

        // random groups, all requirements against the model
        for (int t = 0; t < 600; t++) begin
            for (int j = 0; j < LN; j++) grp[j] = rnd_insn();
            gv = ($urandom % 5 == 0) ? 4'($urandom) : 4'hF;
            apply("R3 random");
        end

        // R1 reset mid-run
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset mid-run", {28'd0, out_vld}, 32'd0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule